// File: doc/BRIEF.md
# Hotplug Slot Status Bank

This block records slot insertion and removal requests for a small set of selectable buses, each with up to 32 slots. Firmware reaches it through a window of 32-bit word registers. It first picks a bus through a select register, then reads that bus's arrival bitmap, pending-removal bitmap and removable mask. Writing a slot bitmap to the eject register acknowledges a removal. The block then emits a one-cycle eject strobe naming the bus and slot, which the unplug machinery downstream acts on.

Plug events and removal requests come in on dedicated inputs, each tagged with a bus index and a slot number. Either kind raises a level event toward the interrupt controller. A legacy mode keeps the arrival bitmap across reads and pins the bus select to bus 0.

A warm reset starts a drain sequence that keeps the bitmaps. It retires every pending removal, one slot per clock, and then loads the removable mask from the non-removable input. The register port stays silent until the drain is done. A power-on reset (`rst_n`) clears all state and then runs the same, now empty, drain.

Top module: `hp_slot_bank`

## Requirements
- R1: After reset and the drain that follows it, the event and eject outputs are low, the select register reads 0, the bitmaps read 0, and each bus's removable register (byte offset 0x0C) reads the inverse of that bus's slice of `fixed_mask`. Bit `b*32+s` of `fixed_mask` set means slot s of bus b cannot be removed.
- R2: A read of offset 0x00 returns the selected bus's arrival bitmap, bit s for slot s. Outside legacy mode the read also clears that bitmap. In legacy mode the bitmap is left intact.
- R3: A read of offset 0x04 returns the pending-removal bitmap and leaves it unchanged. A read of offset 0x08 always returns 0, and so does a read of any other address, including addresses that are not word aligned.
- R4: When the select register holds a value of 4 or more (any 32-bit value, including ones whose top bit is set), every read returns 0 and eject writes have no effect.
- R5: An eject write (offset 0x08) with nonzero data targets the lowest set bit of the data. That slot's bit is cleared in both bitmaps of the selected bus. If the slot's removable bit is 1, `eject_vld` pulses for one cycle in the cycle after the write, with `eject_bus` and `eject_slot` naming the target. Write data of zero does nothing.
- R6: A write to offset 0x10 stores the 32-bit data as the bus select. In legacy mode the select becomes 0 instead. Reading offset 0x10 returns the select.
- R7: A plug event sets slot s of bus b in the arrival bitmap, and a removal request sets it in the removal bitmap. Both are visible from the next cycle and both raise `event_o`. Requests naming bus 4 or more are dropped and do not touch `event_o`.
- R8: `event_o` stays high until a read of offset 0x00 or 0x04 on any bus. If an accepted request comes in the cycle of that read, `event_o` stays high.
- R9: When a request and a clearing action (a clearing read, an eject write, or a drain step) hit the same bit in the same cycle, the bit ends up set.
- R10: `warm_rst` zeroes the select and the event and keeps both bitmaps. Each following cycle, the drain retires the lowest set slot of the lowest-numbered bus that has removals pending. It clears both bits of that slot and pulses the eject strobe unless `fixed_mask` marks the slot. One cycle after the last removal is gone, the removable registers load from `fixed_mask`. Until then every read returns 0 and every write is ignored.
- R11: A plug event and a removal request in the same cycle are both recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all state |
| warm_rst | input | 1 | Synchronous reset that starts the removal drain |
| legacy_mode | input | 1 | Keeps the arrival bitmap on read and pins the select to 0 |
| reg_addr | input | 5 | Byte address within the register window |
| reg_rd | input | 1 | Read strobe; read data is combinational in the same cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when no read is active |
| plug_vld | input | 1 | Plug event strobe |
| plug_bus | input | 3 | Bus index of the plug event |
| plug_slot | input | 5 | Slot number of the plug event |
| rmv_vld | input | 1 | Removal request strobe |
| rmv_bus | input | 3 | Bus index of the removal request |
| rmv_slot | input | 5 | Slot number of the removal request |
| fixed_mask | input | 128 | Non-removable slots, bit b*32+s for bus b slot s |
| eject_vld | output | 1 | One-cycle eject strobe |
| eject_bus | output | 2 | Bus of the ejected slot |
| eject_slot | output | 5 | Ejected slot |
| event_o | output | 1 | Level event toward the interrupt controller |

## Verification
Two operations can land on the same bitmap bit in one cycle: a request that sets it, and a register action that clears it. The register action is a destructive read of the arrival bitmap, an eject write, or a drain step. The same overlap happens on the event output, which a register read clears while a request sets it. The bench drives these pairs on the same cycle on purpose, both in directed cases and in a long randomized stretch. It then compares every output on every cycle against a behavioural model in which the set is always applied after the clear.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int HP_DATA_W = 32;
    localparam int HP_ADDR_W = 5;

    localparam logic [HP_ADDR_W-1:0] OFS_ARRIVE = 5'h00;
    localparam logic [HP_ADDR_W-1:0] OFS_REMOVE = 5'h04;
    localparam logic [HP_ADDR_W-1:0] OFS_EJECT  = 5'h08;
    localparam logic [HP_ADDR_W-1:0] OFS_RMVBL  = 5'h0C;
    localparam logic [HP_ADDR_W-1:0] OFS_SELECT = 5'h10;

    localparam logic [HP_DATA_W-1:0] SEL_DEFAULT = '0;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
    parameter int W  = 32,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/hp_drain_pick.sv
module hp_drain_pick #(
    parameter int NUM_BUS  = 4,
    parameter int NUM_SLOT = 32,
    localparam int BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
    localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
    input  logic [NUM_BUS-1:0][NUM_SLOT-1:0] pend,
    output logic                             found,
    output logic [BUS_W-1:0]                 bus,
    output logic [SLOT_W-1:0]                slot
);
    logic [NUM_BUS-1:0] bus_any;
    logic [SLOT_W-1:0]  bus_idx [NUM_BUS];

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
        hp_lowbit #(.W(NUM_SLOT), .IW(SLOT_W)) u_low (
            .vec (pend[g]),
            .any (bus_any[g]),
            .idx (bus_idx[g])
        );
    end

    always_comb begin
        found = 1'b0;
        bus   = '0;
        slot  = '0;
        for (int b = NUM_BUS - 1; b >= 0; b--) begin
            if (bus_any[b]) begin
                found = 1'b1;
                bus   = BUS_W'(b);
                slot  = bus_idx[b];
            end
        end
    end
endmodule

// File: rtl/hp_read_mux.sv
module hp_read_mux
    import hp_pkg::*;
#(
    parameter int NUM_SLOT = 32
) (
    input  logic [HP_ADDR_W-1:0] addr,
    input  logic                 rd,
    input  logic                 ready,
    input  logic                 sel_ok,
    input  logic [NUM_SLOT-1:0]  arrive_w,
    input  logic [NUM_SLOT-1:0]  remove_w,
    input  logic [NUM_SLOT-1:0]  rmvbl_w,
    input  logic [HP_DATA_W-1:0] sel,
    output logic [HP_DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd && ready && sel_ok) begin
            case (addr)
                OFS_ARRIVE: rdata = HP_DATA_W'(arrive_w);
                OFS_REMOVE: rdata = HP_DATA_W'(remove_w);
                OFS_RMVBL:  rdata = HP_DATA_W'(rmvbl_w);
                OFS_SELECT: rdata = sel;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
    import hp_pkg::*;
#(
    parameter int NUM_BUS   = 4,
    parameter int NUM_SLOT  = 32,
    localparam int BUS_W    = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
    localparam int BIW      = BUS_W + 1,
    localparam int SLOT_W   = $clog2(NUM_SLOT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        warm_rst,
    input  logic                        legacy_mode,
    input  logic [HP_ADDR_W-1:0]        reg_addr,
    input  logic                        reg_rd,
    input  logic                        reg_wr,
    input  logic [HP_DATA_W-1:0]        reg_wdata,
    output logic [HP_DATA_W-1:0]        reg_rdata,
    input  logic                        plug_vld,
    input  logic [BIW-1:0]              plug_bus,
    input  logic [SLOT_W-1:0]           plug_slot,
    input  logic                        rmv_vld,
    input  logic [BIW-1:0]              rmv_bus,
    input  logic [SLOT_W-1:0]           rmv_slot,
    input  logic [NUM_BUS*NUM_SLOT-1:0] fixed_mask,
    output logic                        eject_vld,
    output logic [BUS_W-1:0]            eject_bus,
    output logic [SLOT_W-1:0]           eject_slot,
    output logic                        event_o
);
    typedef logic [NUM_BUS-1:0][NUM_SLOT-1:0] bitmap_t;

    typedef struct packed {
        bitmap_t              arrive;
        bitmap_t              remove;
        bitmap_t              rmvbl;
        logic [HP_DATA_W-1:0] sel;
        logic                 ev;
        logic                 ready;
        logic                 ej_vld;
        logic [BUS_W-1:0]     ej_bus;
        logic [SLOT_W-1:0]    ej_slot;
    } state_t;

    state_t st_d, st_q;

    bitmap_t fixed_2d;
    assign fixed_2d = fixed_mask;

    // selected bus
    logic             sel_ok;
    logic [BUS_W-1:0] sel_idx;
    assign sel_ok  = (st_q.sel < HP_DATA_W'(NUM_BUS));
    assign sel_idx = st_q.sel[BUS_W-1:0];

    // request acceptance
    logic plug_ok, rmv_ok;
    assign plug_ok = plug_vld && (plug_bus < BIW'(NUM_BUS));
    assign rmv_ok  = rmv_vld  && (rmv_bus  < BIW'(NUM_BUS));

    // lowest set bit of eject write data
    logic              wd_any;
    logic [SLOT_W-1:0] wd_slot;
    hp_lowbit #(.W(NUM_SLOT), .IW(SLOT_W)) u_wd_low (
        .vec (reg_wdata[NUM_SLOT-1:0]),
        .any (wd_any),
        .idx (wd_slot)
    );

    // drain target
    logic              dr_found;
    logic [BUS_W-1:0]  dr_bus;
    logic [SLOT_W-1:0] dr_slot;
    hp_drain_pick #(.NUM_BUS(NUM_BUS), .NUM_SLOT(NUM_SLOT)) u_drain (
        .pend  (st_q.remove),
        .found (dr_found),
        .bus   (dr_bus),
        .slot  (dr_slot)
    );

    hp_read_mux #(.NUM_SLOT(NUM_SLOT)) u_rmux (
        .addr     (reg_addr),
        .rd       (reg_rd),
        .ready    (st_q.ready),
        .sel_ok   (sel_ok),
        .arrive_w (st_q.arrive[sel_idx]),
        .remove_w (st_q.remove[sel_idx]),
        .rmvbl_w  (st_q.rmvbl[sel_idx]),
        .sel      (st_q.sel),
        .rdata    (reg_rdata)
    );

    logic rd_status, rd_clear, wr_eject, wr_select;
    assign rd_status = reg_rd && ((reg_addr == OFS_ARRIVE) || (reg_addr == OFS_REMOVE));
    assign rd_clear  = reg_rd && sel_ok && (reg_addr == OFS_ARRIVE) && !legacy_mode;
    assign wr_eject  = reg_wr && sel_ok && (reg_addr == OFS_EJECT) && wd_any;
    assign wr_select = reg_wr && (reg_addr == OFS_SELECT);

    always_comb begin
        st_d        = st_q;
        st_d.ej_vld = 1'b0;
        if (warm_rst) begin
            st_d.ready = 1'b0;
            st_d.sel   = SEL_DEFAULT;
            st_d.ev    = 1'b0;
        end else begin
            if (!st_q.ready) begin
                if (dr_found) begin
                    st_d.arrive[dr_bus][dr_slot] = 1'b0;
                    st_d.remove[dr_bus][dr_slot] = 1'b0;
                    st_d.ej_vld  = ~fixed_2d[dr_bus][dr_slot];
                    st_d.ej_bus  = dr_bus;
                    st_d.ej_slot = dr_slot;
                end else begin
                    st_d.ready = 1'b1;
                    st_d.rmvbl = ~fixed_2d;
                end
            end else begin
                if (rd_clear) st_d.arrive[sel_idx] = '0;
                if (rd_status) st_d.ev = 1'b0;
                if (wr_eject) begin
                    st_d.arrive[sel_idx][wd_slot] = 1'b0;
                    st_d.remove[sel_idx][wd_slot] = 1'b0;
                    st_d.ej_vld  = st_q.rmvbl[sel_idx][wd_slot];
                    st_d.ej_bus  = sel_idx;
                    st_d.ej_slot = wd_slot;
                end
                if (wr_select) st_d.sel = legacy_mode ? SEL_DEFAULT : reg_wdata;
            end
            // requests applied last so they win over any clear
            if (plug_ok) begin
                st_d.arrive[plug_bus[BUS_W-1:0]][plug_slot] = 1'b1;
                st_d.ev = 1'b1;
            end
            if (rmv_ok) begin
                st_d.remove[rmv_bus[BUS_W-1:0]][rmv_slot] = 1'b1;
                st_d.ev = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eject_vld  = st_q.ej_vld;
    assign eject_bus  = st_q.ej_bus;
    assign eject_slot = st_q.ej_slot;
    assign event_o    = st_q.ev;

    // R7
    plug_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_vld && (plug_bus < BIW'(NUM_BUS)) && !warm_rst)
        |=> st_q.arrive[$past(plug_bus[BUS_W-1:0])][$past(plug_slot)]);

    // R8
    request_raises_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rmv_vld && (rmv_bus < BIW'(NUM_BUS))) && !warm_rst) |=> event_o);

    // R4
    eject_out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ready && !warm_rst && reg_wr && (reg_addr == OFS_EJECT)
         && (st_q.sel >= HP_DATA_W'(NUM_BUS))) |=> !eject_vld);

    // R10
    drain_port_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ready |-> (reg_rdata == '0));

    // R6
    legacy_select_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ready && !warm_rst && reg_wr && (reg_addr == OFS_SELECT) && legacy_mode)
        |=> (st_q.sel == SEL_DEFAULT));
endmodule

// File: tb/hp_slot_bank_tb.sv
module hp_slot_bank_tb_top;
    localparam int CLK_P = 10;
    localparam int NB = 4;
    localparam int NS = 32;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic         rst_n, warm_rst, legacy_mode;
    logic [4:0]   reg_addr;
    logic         reg_rd, reg_wr;
    logic [31:0]  reg_wdata, reg_rdata;
    logic         plug_vld, rmv_vld;
    logic [2:0]   plug_bus, rmv_bus;
    logic [4:0]   plug_slot, rmv_slot;
    logic [NB*NS-1:0] fixed_mask;
    logic         eject_vld, event_o;
    logic [1:0]   eject_bus;
    logic [4:0]   eject_slot;

    hp_slot_bank dut_i (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .legacy_mode(legacy_mode),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .plug_vld(plug_vld), .plug_bus(plug_bus),
        .plug_slot(plug_slot), .rmv_vld(rmv_vld), .rmv_bus(rmv_bus),
        .rmv_slot(rmv_slot), .fixed_mask(fixed_mask), .eject_vld(eject_vld),
        .eject_bus(eject_bus), .eject_slot(eject_slot), .event_o(event_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model
    logic [31:0] m_arr [NB];
    logic [31:0] m_rem [NB];
    logic [31:0] m_rbl [NB];
    logic [31:0] m_sel;
    bit m_ev, m_ready, m_ejv;
    int m_ejb, m_ejs;

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic bit fixed_at(input int b, input int s);
        return fixed_mask[b*NS + s];
    endfunction

    function automatic logic [31:0] exp_rdata();
        if (!reg_rd || !m_ready || m_sel >= NB) return 32'd0;
        case (reg_addr)
            5'h00: return m_arr[m_sel];
            5'h04: return m_rem[m_sel];
            5'h0C: return m_rbl[m_sel];
            5'h10: return m_sel;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit ok;
        int b, s;
        ok = (m_sel < NB);
        m_ejv = 1'b0;
        if (warm_rst) begin
            m_ready = 1'b0; m_sel = 0; m_ev = 1'b0;
            return;
        end
        if (!m_ready) begin
            b = -1;
            for (int i = NB - 1; i >= 0; i--) if (m_rem[i] != 0) b = i;
            if (b >= 0) begin
                s = lowest(m_rem[b]);
                m_arr[b][s] = 1'b0; m_rem[b][s] = 1'b0;
                m_ejv = !fixed_at(b, s); m_ejb = b; m_ejs = s;
            end else begin
                m_ready = 1'b1;
                for (int i = 0; i < NB; i++) m_rbl[i] = ~fixed_mask[i*NS +: NS];
            end
        end else begin
            if (reg_rd && ok && reg_addr == 5'h00 && !legacy_mode) m_arr[m_sel] = 0;
            if (reg_rd && (reg_addr == 5'h00 || reg_addr == 5'h04)) m_ev = 1'b0;
            if (reg_wr && ok && reg_addr == 5'h08 && reg_wdata != 0) begin
                s = lowest(reg_wdata);
                m_arr[m_sel][s] = 1'b0; m_rem[m_sel][s] = 1'b0;
                m_ejv = m_rbl[m_sel][s]; m_ejb = int'(m_sel); m_ejs = s;
            end
            if (reg_wr && reg_addr == 5'h10) m_sel = legacy_mode ? 32'd0 : reg_wdata;
        end
        if (plug_vld && plug_bus < NB) begin m_arr[plug_bus][plug_slot] = 1'b1; m_ev = 1'b1; end
        if (rmv_vld && rmv_bus < NB) begin m_rem[rmv_bus][rmv_slot] = 1'b1; m_ev = 1'b1; end
    endtask

    task automatic tick(input string tag);
        #(CLK_P/4);
        check(tag, "rdata", reg_rdata, exp_rdata());
        check(tag, "event", {31'd0, event_o}, {31'd0, m_ev});
        check(tag, "eject_vld", {31'd0, eject_vld}, {31'd0, m_ejv});
        if (m_ejv) begin
            check(tag, "eject_bus", {30'd0, eject_bus}, 32'(m_ejb));
            check(tag, "eject_slot", {27'd0, eject_slot}, 32'(m_ejs));
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        warm_rst = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        plug_vld = 0; rmv_vld = 0; plug_bus = 0; rmv_bus = 0; plug_slot = 0; rmv_slot = 0;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        reg_rd = 1; reg_addr = a; tick(tag); reg_rd = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick(tag); reg_wr = 0;
    endtask

    task automatic plug(input int b, input int s, input string tag);
        plug_vld = 1; plug_bus = 3'(b); plug_slot = 5'(s); tick(tag); plug_vld = 0;
    endtask

    task automatic remreq(input int b, input int s, input string tag);
        rmv_vld = 1; rmv_bus = 3'(b); rmv_slot = 5'(s); tick(tag); rmv_vld = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; legacy_mode = 0; idle();
        fixed_mask = '0;
        fixed_mask[0*NS + 3] = 1'b1;
        fixed_mask[2*NS + 0] = 1'b1;
        for (int i = 0; i < NB; i++) begin m_arr[i] = 0; m_rem[i] = 0; m_rbl[i] = 0; end
        m_sel = 0; m_ev = 0; m_ready = 0; m_ejv = 0; m_ejb = 0; m_ejs = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state and removable mask
        tick("R1"); tick("R1");
        rd(5'h0C, "R1"); rd(5'h10, "R1"); rd(5'h00, "R1"); rd(5'h04, "R1");
        wr(5'h10, 32'd2, "R1"); rd(5'h0C, "R1"); wr(5'h10, 32'd0, "R1");

        // R7 / R2 / R8
        plug(0, 5, "R7");
        rd(5'h00, "R2"); rd(5'h00, "R2"); tick("R8");
        plug(4, 1, "R7"); plug(7, 9, "R7"); rd(5'h00, "R7");

        // R11 same-cycle plug and removal
        plug_vld = 1; plug_bus = 0; plug_slot = 6; rmv_vld = 1; rmv_bus = 0; rmv_slot = 6;
        tick("R11"); idle();
        remreq(0, 5, "R7"); remreq(0, 3, "R7");

        // R3
        rd(5'h04, "R3"); rd(5'h04, "R3"); rd(5'h08, "R3"); rd(5'h14, "R3"); rd(5'h02, "R3");

        // R5 eject lowest bit, non-removable, zero data
        wr(5'h08, 32'h60, "R5"); tick("R5");
        wr(5'h08, 32'h08, "R5"); tick("R5");
        wr(5'h08, 32'h0, "R5"); rd(5'h04, "R5"); rd(5'h00, "R5");

        // R6 / R4
        remreq(2, 0, "R6"); remreq(2, 17, "R6");
        wr(5'h10, 32'd2, "R6"); rd(5'h10, "R6"); rd(5'h04, "R6");
        wr(5'h08, 32'h1, "R5"); tick("R5");
        wr(5'h10, 32'd7, "R4"); rd(5'h04, "R4"); rd(5'h10, "R4");
        wr(5'h08, 32'hFFFF_FFFF, "R4"); tick("R4");
        wr(5'h10, 32'hFFFF_FFFF, "R4"); rd(5'h0C, "R4");
        wr(5'h10, 32'd2, "R4"); rd(5'h04, "R4");

        // legacy mode
        legacy_mode = 1;
        wr(5'h10, 32'd3, "R6"); rd(5'h10, "R6");
        plug(0, 9, "R2"); rd(5'h00, "R2"); rd(5'h00, "R2");
        legacy_mode = 0;
        rd(5'h00, "R2"); rd(5'h00, "R2");

        // R8 / R9 collisions
        plug(0, 12, "R8");
        reg_rd = 1; reg_addr = 5'h00; plug_vld = 1; plug_bus = 0; plug_slot = 12;
        tick("R9"); idle(); rd(5'h00, "R9");
        remreq(0, 20, "R9");
        reg_wr = 1; reg_addr = 5'h08; reg_wdata = 32'h0010_0000;
        rmv_vld = 1; rmv_bus = 0; rmv_slot = 20;
        tick("R9"); idle(); rd(5'h04, "R9");
        reg_rd = 1; reg_addr = 5'h04; rmv_vld = 1; rmv_bus = 1; rmv_slot = 1;
        tick("R8"); idle(); tick("R8");

        // R10 warm-reset drain
        remreq(1, 9, "R10"); remreq(1, 2, "R10"); remreq(3, 0, "R10"); remreq(2, 0, "R10");
        plug(1, 2, "R10");
        warm_rst = 1; tick("R10"); warm_rst = 0;
        for (int k = 0; k < 40 && !m_ready; k++) begin
            reg_rd = 1; reg_addr = 5'h04;
            reg_wr = (k == 1); reg_wdata = 32'd3;
            if (k == 2) begin rmv_vld = 1; rmv_bus = 3; rmv_slot = 31; end
            tick("R10");
            idle();
        end
        rd(5'h10, "R10"); rd(5'h04, "R10"); rd(5'h0C, "R10");
        wr(5'h10, 32'd1, "R10"); rd(5'h04, "R10"); rd(5'h00, "R10");

        // randomized stretch
        for (int k = 0; k < 3000; k++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            if (r < 2) warm_rst = 1;
            plug_vld = ($urandom_range(0, 3) == 0);
            plug_bus = 3'($urandom_range(0, 4));
            plug_slot = 5'($urandom_range(0, 7));
            rmv_vld = ($urandom_range(0, 3) == 0);
            rmv_bus = 3'($urandom_range(0, 4));
            rmv_slot = 5'($urandom_range(0, 7));
            reg_rd = ($urandom_range(0, 2) == 0);
            reg_wr = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 5))
                0: reg_addr = 5'h00;
                1: reg_addr = 5'h04;
                2: reg_addr = 5'h08;
                3: reg_addr = 5'h0C;
                4: reg_addr = 5'h10;
                default: reg_addr = 5'($urandom_range(0, 31));
            endcase
            if (reg_addr == 5'h10) reg_wdata = 32'($urandom_range(0, 5));
            else reg_wdata = 32'($urandom_range(0, 255));
            legacy_mode = ($urandom_range(0, 15) == 0);
            tick("R9");
        end
        idle(); legacy_mode = 0; tick("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule